// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers thirty-two interrupt lines and points the processor at the service routine of the most urgent one. Each line has its own enable bit, a three-bit priority, a vector address that software can rewrite at any time, and a selector that picks which of three request inputs triggers it: a fixed-function peripheral request, a DMA completion request, or a request routed from programmable logic. A rising edge on the selected input marks the line pending. Software can also force a line pending or withdraw a pending request.

The controller compares every line that is both pending and enabled and presents the winner as a request flag, a five-bit line index and that line's vector address. The processor takes the request with a one-cycle acknowledge, which clears the line's pending bit and records the line's priority level as in service. A later request interrupts that service only if its priority is strictly more urgent. An end-of-service strobe retires the most urgent level that is in service.

A small state machine drives the processor side. It has three states. ST_IDLE means nothing is presented. ST_PRESENT means the request flag is high and the index and vector follow the current winner on every cycle. ST_ACKED lasts one cycle after an acknowledge, with the flag low and the presented index and vector frozen. It has four transitions. T_RAISE goes from ST_IDLE to ST_PRESENT when a qualified winner exists. T_TAKE goes from ST_PRESENT to ST_ACKED on an acknowledge. T_WITHDRAW goes from ST_PRESENT to ST_IDLE when no qualified winner remains. T_RELEASE goes from ST_ACKED back to ST_IDLE on the next cycle.

Top module: `prio_vec_intc`

## Requirements
- R1: The two-bit source selector of a line chooses the trigger: 0 fixed-function input, 1 DMA input, 2 programmable-logic input, 3 no hardware source. The pending bit is set by a rising edge on the chosen input, meaning low in one sampled cycle and high in the next. Edges on the inputs that are not chosen leave the pending bit unchanged.
- R2: Only lines that are both pending and enabled take part in arbitration. A pending line that is disabled stays pending and competes again once it is enabled.
- R3: Priority 0 is the most urgent and 7 the least. Among lines of equal priority, the lowest line index wins.
- R4: irq_vec always carries the vector address currently programmed for the presented line, including a rewrite made while that line is being presented.
- R5: Configuration operations select a line with cfg_line and take effect on the clock edge where cfg_we is high. Operation 4 sets the pending bit and operation 5 clears it. A hardware edge or a software set arriving in the same cycle as a clear leaves the bit set.
- R6: Operation 0 sets and operation 1 clears the enable bit. en_state shows the enable bit of the line selected by cfg_line. Operation 2 loads the priority from cfg_data[2:0], operation 3 loads the vector from cfg_data, operation 6 loads the source selector from cfg_data[1:0], and operation 7 does nothing.
- R7: A request edge sampled at clock edge k makes irq_req high after edge k+1. While irq_req is high, irq_idx and irq_vec follow the winner with a one-cycle lag.
- R8: An irq_ack sampled while irq_req is high drops irq_req for exactly the following cycle while irq_idx and irq_vec hold. The acknowledged line's pending bit is cleared and its priority level is marked in service.
- R9: While any level is in service, a winner is presented only if its priority number is strictly less than the most urgent level in service.
- R10: An irq_eoi pulse removes the most urgent level in service. Less urgent levels stay in service and become the new limit.
- R11: After reset all lines are disabled, with priority 7, vector 0, source selector 0 and nothing pending. irq_req is low and no level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_fixed | input | 32 | Fixed-function request per line |
| src_dma | input | 32 | DMA request per line |
| src_route | input | 32 | Programmable-logic request per line |
| cfg_we | input | 1 | Configuration strobe |
| cfg_op | input | 3 | Configuration operation code |
| cfg_line | input | 5 | Line addressed by the operation and by en_state |
| cfg_data | input | 16 | Operand: priority, vector or source selector |
| en_state | output | 1 | Enable bit of the line addressed by cfg_line |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_idx | output | 5 | Index of the presented line |
| irq_vec | output | 16 | Vector address of the presented line |
| irq_ack | input | 1 | Processor takes the presented request |
| irq_eoi | input | 1 | Processor ends service of the most urgent active level |

## Verification
Directed sequences first separate the arbitration rules one at a time. A tie at equal priority tests the index ordering. Disabling a line that would otherwise win tests the enable gating. Pulses on the inputs that a line has not selected show that those edges are ignored. Acknowledging in nested order tests the rule that a request of equal urgency stays blocked while a strictly more urgent one gets through, followed by a chain of end-of-service strobes that lifts the limit one level at a time. One pulse is timed cycle by cycle to pin the two-edge latency. One case puts a hardware edge and a software clear in the same cycle to show which one wins. A seeded random phase then mixes configuration writes, source pulses, acknowledges and end-of-service strobes over a handful of lines, and after each step compares the presented request, index and vector against a bench-side model of the pending, enable and in-service state.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    typedef enum logic [2:0] {
        OP_EN_SET   = 3'd0,
        OP_EN_CLR   = 3'd1,
        OP_PRIO     = 3'd2,
        OP_VECT     = 3'd3,
        OP_PEND_SET = 3'd4,
        OP_PEND_CLR = 3'd5,
        OP_SRC      = 3'd6,
        OP_NONE     = 3'd7
    } cfg_op_e;

    typedef enum logic [1:0] {
        SRC_FIXED = 2'd0,
        SRC_DMA   = 2'd1,
        SRC_ROUTE = 2'd2,
        SRC_OFF   = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PRESENT = 2'd1,
        ST_ACKED   = 2'd2
    } svc_state_e;

endpackage

// File: rtl/pvic_line_bank.sv
module pvic_line_bank
    import pvic_pkg::*;
#(
    parameter int N  = 32,
    parameter int PW = 3,
    parameter int VW = 16,
    parameter int IW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    src_fixed,
    input  logic [N-1:0]    src_dma,
    input  logic [N-1:0]    src_route,
    input  logic            cfg_we,
    input  cfg_op_e         cfg_op,
    input  logic [IW-1:0]   cfg_line,
    input  logic [VW-1:0]   cfg_data,
    input  logic            ack_clr,
    input  logic [IW-1:0]   ack_line,
    output logic [N-1:0]    cand,
    output logic [N*PW-1:0] prio_flat,
    output logic [N*VW-1:0] vec_flat,
    output logic            en_state
);

    logic [N-1:0] en_vec;
    logic [N-1:0] pend_vec;

    for (genvar i = 0; i < N; i++) begin : g_line
        logic          en_q;
        logic [PW-1:0] pr_q;
        logic [VW-1:0] vc_q;
        src_sel_e      sel_q;
        logic [2:0]    prev_q;
        logic          pend_q;
        logic [2:0]    raw;
        logic [3:0]    rise;
        logic          hit, hw_edge, set_req, clr_req;

        assign raw     = {src_route[i], src_dma[i], src_fixed[i]};
        assign rise    = {1'b0, raw & ~prev_q};
        assign hw_edge = rise[sel_q];
        assign hit     = cfg_we && (cfg_line == IW'(i));
        assign set_req = hw_edge || (hit && cfg_op == OP_PEND_SET);
        assign clr_req = (hit && cfg_op == OP_PEND_CLR) ||
                         (ack_clr && ack_line == IW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q   <= 1'b0;
                pr_q   <= '1;
                vc_q   <= '0;
                sel_q  <= SRC_FIXED;
                prev_q <= '0;
                pend_q <= 1'b0;
            end else begin
                prev_q <= raw;
                pend_q <= set_req | (pend_q & ~clr_req);
                if (hit) begin
                    unique case (cfg_op)
                        OP_EN_SET: en_q  <= 1'b1;
                        OP_EN_CLR: en_q  <= 1'b0;
                        OP_PRIO:   pr_q  <= cfg_data[PW-1:0];
                        OP_VECT:   vc_q  <= cfg_data;
                        OP_SRC:    sel_q <= src_sel_e'(cfg_data[1:0]);
                        default:   ;
                    endcase
                end
            end
        end

        assign en_vec[i]               = en_q;
        assign pend_vec[i]             = pend_q;
        assign prio_flat[i*PW +: PW]   = pr_q;
        assign vec_flat[i*VW +: VW]    = vc_q;

        // R1: with no hardware source, only a software set may raise pending
        a_r1_off_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_q == SRC_OFF && !pend_q && !(hit && cfg_op == OP_PEND_SET))
            |=> !pend_q);
    end

    assign cand     = en_vec & pend_vec;
    assign en_state = en_vec[cfg_line];

endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
    parameter int N  = 32,
    parameter int PW = 3,
    parameter int IW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    cand,
    input  logic [N*PW-1:0] prio_flat,
    input  logic            ceil_valid,
    input  logic [PW-1:0]   ceil_prio,
    output logic            win_valid,
    output logic [IW-1:0]   win_idx,
    output logic [PW-1:0]   win_prio
);

    logic found;

    always_comb begin
        found    = 1'b0;
        win_prio = '1;
        win_idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || prio_flat[i*PW +: PW] < win_prio)) begin
                found    = 1'b1;
                win_prio = prio_flat[i*PW +: PW];
                win_idx  = IW'(i);
            end
        end
        win_valid = found && (!ceil_valid || win_prio < ceil_prio);
    end

    for (genvar j = 0; j < N; j++) begin : g_chk
        // R3: no competing line is more urgent, and ties favour the lower index
        a_r3_best_choice: assert property (@(posedge clk) disable iff (!rst_n)
            (win_valid && cand[j]) |->
                (prio_flat[j*PW +: PW] > win_prio) ||
                (prio_flat[j*PW +: PW] == win_prio && win_idx <= IW'(j)));
    end

endmodule

// File: rtl/pvic_service.sv
module pvic_service
    import pvic_pkg::*;
#(
    parameter int N  = 32,
    parameter int PW = 3,
    parameter int VW = 16,
    parameter int IW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            win_valid,
    input  logic [IW-1:0]   win_idx,
    input  logic [N*PW-1:0] prio_flat,
    input  logic [N*VW-1:0] vec_flat,
    input  logic            irq_ack,
    input  logic            irq_eoi,
    output logic            irq_req,
    output logic [IW-1:0]   irq_idx,
    output logic [VW-1:0]   irq_vec,
    output logic            ack_clr,
    output logic [IW-1:0]   ack_line,
    output logic            ceil_valid,
    output logic [PW-1:0]   ceil_prio
);

    localparam int LV = 1 << PW;

    svc_state_e    state_q, state_d;
    logic [IW-1:0] idx_q;
    logic [LV-1:0] isr_q, isr_d, eoi_mask, ack_mask;
    logic [PW-1:0] ack_prio;
    logic          load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (win_valid) state_d = ST_PRESENT;          // T_RAISE
            ST_PRESENT: if (irq_ack)   state_d = ST_ACKED;            // T_TAKE
                        else if (!win_valid) state_d = ST_IDLE;       // T_WITHDRAW
            ST_ACKED:   state_d = ST_IDLE;                            // T_RELEASE
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_req = 1'b0;
        ack_clr = 1'b0;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE:    load = win_valid;
            ST_PRESENT: begin
                irq_req = 1'b1;
                ack_clr = irq_ack;
                load    = win_valid && !irq_ack;
            end
            ST_ACKED:   ;
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else if (load) idx_q <= win_idx;
    end

    assign irq_idx  = idx_q;
    assign irq_vec  = vec_flat[idx_q*VW +: VW];
    assign ack_line = idx_q;
    assign ack_prio = prio_flat[idx_q*PW +: PW];

    // in-service levels
    assign eoi_mask = irq_eoi ? (isr_q & (~isr_q + LV'(1))) : '0;
    assign ack_mask = ack_clr ? (LV'(1) << ack_prio) : '0;
    assign isr_d    = (isr_q & ~eoi_mask) | ack_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_d;
    end

    always_comb begin
        ceil_prio = '0;
        for (int i = LV - 1; i >= 0; i--) begin
            if (isr_q[i]) ceil_prio = PW'(i);
        end
    end
    assign ceil_valid = |isr_q;

    // R7: a qualified winner seen while idle raises the request next cycle
    a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && win_valid) |=> irq_req);

    // R8: after an acknowledge the request drops and the presented line holds
    a_r8_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> (!irq_req && $stable(irq_idx)));

    // R10: an end-of-service strobe with no acknowledge retires exactly one level
    a_r10_eoi_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_eoi && !ack_clr && ceil_valid) |=>
            ($countones(isr_q) + 1 == $past($countones(isr_q))));

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import pvic_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int PRIO_W  = 3,
    parameter int VEC_W   = 16,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] src_fixed,
    input  logic [N_LINES-1:0] src_dma,
    input  logic [N_LINES-1:0] src_route,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_op,
    input  logic [IDX_W-1:0]   cfg_line,
    input  logic [VEC_W-1:0]   cfg_data,
    output logic               en_state,
    output logic               irq_req,
    output logic [IDX_W-1:0]   irq_idx,
    output logic [VEC_W-1:0]   irq_vec,
    input  logic               irq_ack,
    input  logic               irq_eoi
);

    logic [N_LINES-1:0]        cand;
    logic [N_LINES*PRIO_W-1:0] prio_flat;
    logic [N_LINES*VEC_W-1:0]  vec_flat;
    logic                      ack_clr;
    logic [IDX_W-1:0]          ack_line;
    logic                      ceil_valid;
    logic [PRIO_W-1:0]         ceil_prio;
    logic                      win_valid;
    logic [IDX_W-1:0]          win_idx;
    logic [PRIO_W-1:0]         win_prio;

    pvic_line_bank #(.N(N_LINES), .PW(PRIO_W), .VW(VEC_W), .IW(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_fixed (src_fixed),
        .src_dma   (src_dma),
        .src_route (src_route),
        .cfg_we    (cfg_we),
        .cfg_op    (cfg_op_e'(cfg_op)),
        .cfg_line  (cfg_line),
        .cfg_data  (cfg_data),
        .ack_clr   (ack_clr),
        .ack_line  (ack_line),
        .cand      (cand),
        .prio_flat (prio_flat),
        .vec_flat  (vec_flat),
        .en_state  (en_state)
    );

    pvic_arbiter #(.N(N_LINES), .PW(PRIO_W), .IW(IDX_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand       (cand),
        .prio_flat  (prio_flat),
        .ceil_valid (ceil_valid),
        .ceil_prio  (ceil_prio),
        .win_valid  (win_valid),
        .win_idx    (win_idx),
        .win_prio   (win_prio)
    );

    pvic_service #(.N(N_LINES), .PW(PRIO_W), .VW(VEC_W), .IW(IDX_W)) u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_valid  (win_valid),
        .win_idx    (win_idx),
        .prio_flat  (prio_flat),
        .vec_flat   (vec_flat),
        .irq_ack    (irq_ack),
        .irq_eoi    (irq_eoi),
        .irq_req    (irq_req),
        .irq_idx    (irq_idx),
        .irq_vec    (irq_vec),
        .ack_clr    (ack_clr),
        .ack_line   (ack_line),
        .ceil_valid (ceil_valid),
        .ceil_prio  (ceil_prio)
    );

    // R9: a request presented during service is strictly more urgent than the limit
    a_r9_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && ceil_valid) |-> (win_prio < ceil_prio));

endmodule

// File: tb/prio_vec_intc_bench.sv
module prio_vec_intc_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_fixed = '0, src_dma = '0, src_route = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_op = 3'd7;
    logic [4:0]  cfg_line = '0;
    logic [15:0] cfg_data = '0;
    logic        en_state, irq_req;
    logic [4:0]  irq_idx;
    logic [15:0] irq_vec;
    logic        irq_ack = 1'b0, irq_eoi = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit          m_en [32];
    int          m_pr [32];
    logic [15:0] m_vc [32];
    int          m_sr [32];
    bit          m_pd [32];
    bit [7:0]    m_isr;

    always #2 clk = ~clk;

    prio_vec_intc u_prio_vec_intc (
        .clk(clk), .rst_n(rst_n),
        .src_fixed(src_fixed), .src_dma(src_dma), .src_route(src_route),
        .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_line(cfg_line), .cfg_data(cfg_data),
        .en_state(en_state), .irq_req(irq_req), .irq_idx(irq_idx), .irq_vec(irq_vec),
        .irq_ack(irq_ack), .irq_eoi(irq_eoi)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void exp_calc(output bit v, output int idx);
        int ceil = 8;
        int bp = 8;
        idx = 0;
        for (int l = 7; l >= 0; l--) if (m_isr[l]) ceil = l;
        for (int i = 0; i < 32; i++)
            if (m_en[i] && m_pd[i] && m_pr[i] < bp) begin bp = m_pr[i]; idx = i; end
        v = (bp < 8) && (bp < ceil);
    endfunction

    task automatic check_out(input string tag);
        bit v;
        int idx;
        exp_calc(v, idx);
        check({tag, " irq_req"}, 32'(irq_req), 32'(v));
        if (v) begin
            check({tag, " irq_idx"}, 32'(irq_idx), 32'(idx));
            check({tag, " irq_vec"}, 32'(irq_vec), 32'(m_vc[idx]));
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic cfg(input int op, input int line, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_op = 3'(op); cfg_line = 5'(line); cfg_data = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0; cfg_op = 3'd7;
        case (op)
            0: m_en[line] = 1'b1;
            1: m_en[line] = 1'b0;
            2: m_pr[line] = data & 7;
            3: m_vc[line] = 16'(data);
            4: m_pd[line] = 1'b1;
            5: m_pd[line] = 1'b0;
            6: m_sr[line] = data & 3;
            default: ;
        endcase
    endtask

    task automatic drive_src(input int s, input int line, input logic val);
        case (s)
            0: src_fixed[line] = val;
            1: src_dma[line]   = val;
            default: src_route[line] = val;
        endcase
    endtask

    task automatic pulse(input int s, input int line);
        @(negedge clk);
        drive_src(s, line, 1'b1);
        @(negedge clk);
        drive_src(s, line, 1'b0);
        if (m_sr[line] == s) m_pd[line] = 1'b1;
    endtask

    task automatic ack_it(input string tag);
        logic [4:0] held;
        held = irq_idx;
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check({tag, " R8 req low after ack"}, 32'(irq_req), 32'd0);
        check({tag, " R8 idx held"}, 32'(irq_idx), 32'(held));
        m_pd[held] = 1'b0;
        m_isr[m_pr[held]] = 1'b1;
    endtask

    task automatic eoi_it();
        @(negedge clk);
        irq_eoi = 1'b1;
        @(negedge clk);
        irq_eoi = 1'b0;
        for (int l = 0; l < 8; l++) if (m_isr[l]) begin m_isr[l] = 1'b0; break; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0c1a));
        for (int i = 0; i < 32; i++) begin
            m_en[i] = 0; m_pr[i] = 7; m_vc[i] = '0; m_sr[i] = 0; m_pd[i] = 0;
        end
        m_isr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check("R11 irq_req after reset", 32'(irq_req), 32'd0);
        cfg_line = 5'd31;
        @(negedge clk);
        check("R11 en_state line 31", 32'(en_state), 32'd0);

        // R7: exact latency from a source edge
        cfg(0, 5, 0); cfg(2, 5, 4); cfg(3, 5, 16'hABCD);
        @(negedge clk);
        src_fixed[5] = 1'b1;
        @(negedge clk);
        src_fixed[5] = 1'b0;
        m_pd[5] = 1'b1;
        check("R7 not yet raised after first edge", 32'(irq_req), 32'd0);
        @(negedge clk);
        check("R7 raised after second edge", 32'(irq_req), 32'd1);
        check("R4 vector of line 5", 32'(irq_vec), 32'hABCD);

        // R4: vector rewritten while presented
        cfg(3, 5, 16'h1234);
        settle(); check_out("R4 runtime vector");

        // R1: edges on unselected inputs are ignored
        cfg(0, 6, 0); cfg(6, 6, 1); cfg(2, 6, 2);
        pulse(0, 6); pulse(2, 6);
        settle(); check_out("R1 unselected edges ignored");
        check("R1 line 5 still shown", 32'(irq_idx), 32'd5);
        pulse(1, 6);
        settle(); check_out("R1 selected DMA edge");
        check("R1 line 6 now shown", 32'(irq_idx), 32'd6);

        // R3: tie at equal priority goes to the lower index
        cfg(0, 9, 0); cfg(2, 9, 2); cfg(4, 9, 0);
        settle(); check_out("R3 tie lowest index");

        // R2 and R6: disabling removes the line from arbitration
        cfg(1, 6, 0);
        settle(); check_out("R2 disabled line skipped");
        cfg_line = 5'd6; @(negedge clk);
        check("R6 en_state line 6 cleared", 32'(en_state), 32'd0);
        cfg_line = 5'd9; @(negedge clk);
        check("R6 en_state line 9 set", 32'(en_state), 32'd1);

        // R5: software clear and set
        cfg(5, 9, 0);
        settle(); check_out("R5 software clear");
        cfg(0, 3, 0); cfg(4, 3, 0);
        settle(); check_out("R5 software set");

        // R8 and R9: acknowledge then nested preemption
        ack_it("line5");
        settle(); check_out("R9 level 7 blocked by level 4");
        cfg(0, 6, 0);
        settle(); check_out("R9 level 2 preempts level 4");
        ack_it("line6");
        cfg(4, 9, 0);
        settle(); check_out("R9 equal level 2 blocked");
        // R10: end-of-service chain
        eoi_it();
        settle(); check_out("R10 level 2 retired");
        ack_it("line9");
        eoi_it(); eoi_it();
        settle(); check_out("R10 all retired, level 7 shown");
        check("R10 line 3 presented", 32'(irq_idx), 32'd3);

        // R5: hardware edge and clear in the same cycle leave pending set
        cfg(1, 3, 0); cfg(0, 12, 0); cfg(2, 12, 1);
        @(negedge clk);
        src_fixed[12] = 1'b1;
        cfg_we = 1'b1; cfg_op = 3'd5; cfg_line = 5'd12;
        @(negedge clk);
        src_fixed[12] = 1'b0; cfg_we = 1'b0; cfg_op = 3'd7;
        m_pd[12] = 1'b1;
        settle(); check_out("R5 set wins over clear");

        // random phase across R1..R10
        for (int it = 0; it < 300; it++) begin
            int r = $urandom_range(0, 9);
            int ln = ($urandom_range(0, 9) == 0) ? 31 : $urandom_range(0, 7);
            case (r)
                0, 1: cfg(r, ln, 0);
                2: cfg(2, ln, $urandom_range(0, 7));
                3: cfg(3, ln, $urandom_range(0, 65535));
                4, 5: cfg(r, ln, 0);
                6: cfg(6, ln, $urandom_range(0, 3));
                7: pulse($urandom_range(0, 2), ln);
                8: begin
                    bit v; int idx;
                    exp_calc(v, idx);
                    if (v && irq_req) ack_it("random");
                end
                default: eoi_it();
            endcase
            settle();
            check_out("R2/R3/R4/R9 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule